// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block sequences a 12-bit machine with one accumulator. Every instruction goes through a fetch major state and then, if it references memory, an optional defer major state and an execute major state. Each major state is divided into minor steps, and each step raises a set of register-load, ALU and memory strobes. The top three bits of the instruction word select one of eight instruction types. Six of these types reference memory: logical AND, add, increment-and-skip-if-zero, store-and-clear, subroutine call and jump. The remaining two types (device I/O and the operate group) finish as no-ops at the end of fetch.

A small word memory is part of the block so that programs can run against it. A program port writes words into the memory. A separate combinational peek port reads any word back. Memory-reference instructions form their effective address from a 7-bit offset. The offset is placed either in page zero or in the 128-word page that holds the instruction. An indirect bit adds a defer pass that replaces the effective address with the word it points to. The halt input parks the sequencer at the start of fetch, which lets a program be loaded and inspected.

The major states are FETCH (encoding 0), DEFER (encoding 1) and EXEC (encoding 2). The transitions are:
- FETCH step 0 stays in place while halt is high; otherwise it advances step by step to step 3.
- FETCH step 3 (decode) goes to DEFER step 0 when a memory-reference word has the indirect bit set, to EXEC step 0 when that bit is clear, and back to FETCH step 0 for types 6 and 7.
- DEFER step 2 goes to EXEC step 0.
- The last step of each EXEC column raises instr_done and returns to FETCH step 0.

Top module: `acc_seq_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, pc_o and acc_o read 0 and the sequencer sits in FETCH (major_o = 0) at step 0 (minor_o = 0). Reset has the same effect in the middle of an instruction.
- R2: While halt is high and the sequencer is at FETCH step 0, no state advances: major_o, minor_o, pc_o, acc_o and the memory contents all keep their values.
- R3: The opcode is instruction bits [11:9], where the most significant bit is the first bit in the instruction's own numbering. Fetch takes four cycles: the address is loaded, then the word is read while the PC increments, then the word is latched, then it is decoded. Opcodes 6 and 7 end at decode, so the whole instruction takes 4 cycles and leaves the PC one higher.
- R4: Opcode 0 writes ACC AND mem[EA] into the accumulator. Opcode 1 writes ACC + mem[EA] modulo 4096. Each takes 7 cycles when direct.
- R5: Bit 8 set on opcodes 0 to 5 inserts a 3-cycle DEFER pass that reads mem[EA] and uses that word as the new EA. When bit 8 is clear, DEFER is never entered.
- R6: Bits [6:0] give the word offset. Bit 7 clear places it in page zero. Bit 7 set places it in the current page, which is bits [11:7] of the instruction's own address.
- R7: Opcode 2 writes mem[EA]+1 back to memory and takes 8 cycles when direct. When the written value is 0, the PC advances one extra word, so the next instruction is skipped.
- R8: Opcode 3 writes the accumulator to mem[EA] and then clears the accumulator. It takes 6 cycles when direct.
- R9: Opcode 4 writes the address of the following instruction to mem[EA] and continues at EA+1. It takes 6 cycles when direct.
- R10: Opcode 5 loads the PC with EA. It takes 5 cycles when direct and 8 cycles when indirect.
- R11: instr_done is high for exactly the last cycle of each instruction, and the next cycle is FETCH step 0.
- R12: mem_rd and mem_wr are never high together, and mem_wr is high only in EXEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Hold the sequencer at FETCH step 0 |
| prog_we | input | 1 | Program-port write strobe (takes priority over sequencer writes) |
| prog_addr | input | 12 | Program-port word address |
| prog_data | input | 12 | Program-port write data |
| peek_addr | input | 12 | Peek-port word address |
| peek_data | output | 12 | Memory word at peek_addr (combinational) |
| pc_o | output | 12 | Program counter |
| acc_o | output | 12 | Accumulator |
| major_o | output | 2 | Major state: 0 FETCH, 1 DEFER, 2 EXEC |
| minor_o | output | 2 | Minor step within the major state |
| instr_done | output | 1 | Last cycle of the current instruction |
| mem_rd | output | 1 | Sequencer memory read strobe |
| mem_wr | output | 1 | Sequencer memory write strobe |

## Verification
The hardest case to reach from the ports is a skip taken by increment-and-skip. The memory word must be at all-ones before the instruction runs, and the skipped word must be a live instruction whose effect would be visible if it ran. The program places that instruction right after the increment and checks both the PC and the accumulator once the next instruction completes. Current-page addressing also needs care, because it only differs from page zero when code runs outside page zero. To get there, the program takes an indirect jump into page one and keeps different data at the same offset in both pages.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int WORD_W  = 12;
    localparam int OFF_W   = 7;
    localparam int PAGE_W  = WORD_W - OFF_W;
    localparam int OP_W    = 3;
    localparam int MINOR_W = 2;

    typedef enum logic [1:0] {
        MJ_FETCH = 2'd0,
        MJ_DEFER = 2'd1,
        MJ_EXEC  = 2'd2
    } major_e;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_AND  = 2'd1,
        ALU_ADD  = 2'd2
    } alu_e;

    typedef enum logic [1:0] {
        MBR_MEM = 2'd0,
        MBR_ACC = 2'd1,
        MBR_PC  = 2'd2,
        MBR_INC = 2'd3
    } mbr_src_e;

    typedef struct packed {
        logic     mar_ld;
        logic     mar_ea;
        logic     mbr_ld;
        mbr_src_e mbr_src;
        logic     pc_inc;
        logic     pc_ld;
        logic     pc_plus1;
        logic     ir_ld;
        logic     ea_ld;
        logic     ea_ptr;
        logic     acc_ld;
        logic     acc_clr;
        alu_e     alu_fn;
        logic     mem_rd;
        logic     mem_wr;
        logic     done;
    } ctl_t;

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt,
    input  logic [OP_W:0]       ir_hi,
    input  logic                mbr_zero,
    output major_e              major,
    output logic [MINOR_W-1:0]  minor,
    output ctl_t                ctl
);

    major_e             nxt_major;
    logic [MINOR_W-1:0] nxt_minor;
    opcode_e            op;
    logic               indirect;
    logic               mem_ref;

    assign op       = opcode_e'(ir_hi[OP_W:1]);
    assign indirect = ir_hi[0];
    assign mem_ref  = !(ir_hi[OP_W] && ir_hi[OP_W-1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            major <= MJ_FETCH;
            minor <= '0;
        end else begin
            major <= nxt_major;
            minor <= nxt_minor;
        end
    end

    always_comb begin
        ctl       = '0;
        nxt_major = major;
        nxt_minor = minor + 2'd1;
        unique case (major)
            MJ_FETCH: begin
                unique case (minor)
                    2'd0: begin
                        if (halt) nxt_minor = '0;
                        else      ctl.mar_ld = 1'b1;
                    end
                    2'd1: begin
                        ctl.mem_rd  = 1'b1;
                        ctl.mbr_ld  = 1'b1;
                        ctl.mbr_src = MBR_MEM;
                        ctl.pc_inc  = 1'b1;
                    end
                    2'd2: ctl.ir_ld = 1'b1;
                    default: begin
                        nxt_minor = '0;
                        if (!mem_ref) begin
                            ctl.done = 1'b1;
                        end else begin
                            ctl.ea_ld = 1'b1;
                            nxt_major = indirect ? MJ_DEFER : MJ_EXEC;
                        end
                    end
                endcase
            end
            MJ_DEFER: begin
                unique case (minor)
                    2'd0: begin
                        ctl.mar_ld = 1'b1;
                        ctl.mar_ea = 1'b1;
                    end
                    2'd1: begin
                        ctl.mem_rd  = 1'b1;
                        ctl.mbr_ld  = 1'b1;
                        ctl.mbr_src = MBR_MEM;
                    end
                    2'd2: begin
                        ctl.ea_ld  = 1'b1;
                        ctl.ea_ptr = 1'b1;
                        nxt_major  = MJ_EXEC;
                        nxt_minor  = '0;
                    end
                    default: begin
                        nxt_major = MJ_FETCH;
                        nxt_minor = '0;
                    end
                endcase
            end
            MJ_EXEC: begin
                unique case (op)
                    OP_AND, OP_TAD: begin
                        ctl.alu_fn = (op == OP_AND) ? ALU_AND : ALU_ADD;
                        unique case (minor)
                            2'd0: begin
                                ctl.mar_ld = 1'b1;
                                ctl.mar_ea = 1'b1;
                            end
                            2'd1: begin
                                ctl.mem_rd  = 1'b1;
                                ctl.mbr_ld  = 1'b1;
                                ctl.mbr_src = MBR_MEM;
                            end
                            default: begin
                                ctl.acc_ld = 1'b1;
                                ctl.done   = 1'b1;
                            end
                        endcase
                    end
                    OP_ISZ: begin
                        unique case (minor)
                            2'd0: begin
                                ctl.mar_ld = 1'b1;
                                ctl.mar_ea = 1'b1;
                            end
                            2'd1: begin
                                ctl.mem_rd  = 1'b1;
                                ctl.mbr_ld  = 1'b1;
                                ctl.mbr_src = MBR_MEM;
                            end
                            2'd2: begin
                                ctl.mbr_ld  = 1'b1;
                                ctl.mbr_src = MBR_INC;
                            end
                            default: begin
                                ctl.mem_wr = 1'b1;
                                ctl.pc_inc = mbr_zero;
                                ctl.done   = 1'b1;
                            end
                        endcase
                    end
                    OP_DCA: begin
                        if (minor == 2'd0) begin
                            ctl.mar_ld  = 1'b1;
                            ctl.mar_ea  = 1'b1;
                            ctl.mbr_ld  = 1'b1;
                            ctl.mbr_src = MBR_ACC;
                        end else begin
                            ctl.mem_wr  = 1'b1;
                            ctl.acc_clr = 1'b1;
                            ctl.done    = 1'b1;
                        end
                    end
                    OP_JMS: begin
                        if (minor == 2'd0) begin
                            ctl.mar_ld  = 1'b1;
                            ctl.mar_ea  = 1'b1;
                            ctl.mbr_ld  = 1'b1;
                            ctl.mbr_src = MBR_PC;
                        end else begin
                            ctl.mem_wr   = 1'b1;
                            ctl.pc_ld    = 1'b1;
                            ctl.pc_plus1 = 1'b1;
                            ctl.done     = 1'b1;
                        end
                    end
                    OP_JMP: begin
                        ctl.pc_ld = 1'b1;
                        ctl.done  = 1'b1;
                    end
                    default: ctl.done = 1'b1;
                endcase
            end
            default: begin
                nxt_major = MJ_FETCH;
                nxt_minor = '0;
            end
        endcase
        if (ctl.done) begin
            nxt_major = MJ_FETCH;
            nxt_minor = '0;
        end
    end

endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [OP_W:0]     ir_hi,
    output logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] acc,
    output logic              mbr_zero
);

    logic [WORD_W-1:0] mar, mbr, ir, ea;
    logic [WORD_W-1:0] alu_y, ea_direct, mbr_nxt;
    logic [PAGE_W-1:0] page_sel;
    logic              unused_ctl;

    assign unused_ctl = ^{ctl.done, ctl.mem_rd, ctl.mem_wr};

    assign page_sel  = ir[OFF_W] ? mar[WORD_W-1:OFF_W] : '0;
    assign ea_direct = {page_sel, ir[OFF_W-1:0]};

    always_comb begin
        unique case (ctl.alu_fn)
            ALU_AND: alu_y = acc & mbr;
            ALU_ADD: alu_y = acc + mbr;
            default: alu_y = mbr;
        endcase
    end

    always_comb begin
        unique case (ctl.mbr_src)
            MBR_MEM: mbr_nxt = mem_rdata;
            MBR_ACC: mbr_nxt = acc;
            MBR_PC:  mbr_nxt = pc;
            default: mbr_nxt = mbr + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            acc <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            ea  <= '0;
        end else begin
            if (ctl.mar_ld) mar <= ctl.mar_ea ? ea : pc;
            if (ctl.mbr_ld) mbr <= mbr_nxt;
            if (ctl.ir_ld)  ir  <= mbr;
            if (ctl.ea_ld)  ea  <= ctl.ea_ptr ? mbr : ea_direct;
            if (ctl.pc_ld)       pc <= ctl.pc_plus1 ? ea + 1'b1 : ea;
            else if (ctl.pc_inc) pc <= pc + 1'b1;
            if (ctl.acc_clr)     acc <= '0;
            else if (ctl.acc_ld) acc <= alu_y;
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign ir_hi     = ir[WORD_W-1:WORD_W-OP_W-1];
    assign mbr_zero  = (mbr == '0);

endmodule

// File: rtl/acc_seq_mem.sv
module acc_seq_mem
    import acc_seq_pkg::*;
#(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              seq_we,
    input  logic [WORD_W-1:0] seq_addr,
    input  logic [WORD_W-1:0] seq_wdata,
    output logic [WORD_W-1:0] seq_rdata,
    input  logic              prog_we,
    input  logic [WORD_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic [WORD_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [WORD_W-1:0] store [DEPTH];
    logic              unused_hi;

    assign unused_hi = ^{seq_addr[WORD_W-1:MEM_AW], prog_addr[WORD_W-1:MEM_AW],
                         peek_addr[WORD_W-1:MEM_AW]};

    always_ff @(posedge clk) begin
        if (prog_we)     store[prog_addr[MEM_AW-1:0]] <= prog_data;
        else if (seq_we) store[seq_addr[MEM_AW-1:0]]  <= seq_wdata;
    end

    assign seq_rdata = store[seq_addr[MEM_AW-1:0]];
    assign peek_data = store[peek_addr[MEM_AW-1:0]];

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
#(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              prog_we,
    input  logic [WORD_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic [WORD_W-1:0] peek_addr,
    output logic [WORD_W-1:0] peek_data,
    output logic [WORD_W-1:0] pc_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [1:0]        major_o,
    output logic [1:0]        minor_o,
    output logic              instr_done,
    output logic              mem_rd,
    output logic              mem_wr
);

    ctl_t               ctl;
    major_e             major;
    logic [MINOR_W-1:0] minor;
    logic [OP_W:0]      ir_hi;
    logic               mbr_zero;
    logic [WORD_W-1:0]  mem_addr, mem_wdata, mem_rdata;

    acc_seq_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .ir_hi    (ir_hi),
        .mbr_zero (mbr_zero),
        .major    (major),
        .minor    (minor),
        .ctl      (ctl)
    );

    acc_seq_datapath dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir_hi     (ir_hi),
        .pc        (pc_o),
        .acc       (acc_o),
        .mbr_zero  (mbr_zero)
    );

    acc_seq_mem #(.MEM_AW(MEM_AW)) mem_i (
        .clk       (clk),
        .seq_we    (ctl.mem_wr),
        .seq_addr  (mem_addr),
        .seq_wdata (mem_wdata),
        .seq_rdata (mem_rdata),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    assign major_o    = major;
    assign minor_o    = minor;
    assign instr_done = ctl.done;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        halt,
    input logic [1:0]  major,
    input logic [1:0]  minor,
    input logic [11:0] pc,
    input logic [11:0] acc,
    input logic [3:0]  ir_hi,
    input logic        done,
    input logic        rd,
    input logic        wr
);

    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && major == 2'd0 && minor == 2'd0)
        |=> (major == 2'd0 && minor == 2'd0 && $stable(pc) && $stable(acc)));

    a_r3_fetch_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (major == 2'd0 && minor == 2'd1) |=> (pc == $past(pc) + 12'd1));

    a_r5_no_defer_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (major == 2'd0 && minor == 2'd3 && !ir_hi[0]) |=> (major != 2'd1));

    a_r8_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (major == 2'd2 && ir_hi[3:1] == 3'd3 && minor == 2'd1) |=> (acc == 12'd0));

    a_r11_done_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (major == 2'd0 && minor == 2'd0 && !done));

    a_r12_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd, wr}));

    a_r12_write_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (major == 2'd2));

endmodule

bind acc_seq_top acc_seq_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt),
    .major (major_o),
    .minor (minor_o),
    .pc    (pc_o),
    .acc   (acc_o),
    .ir_hi (ir_hi),
    .done  (instr_done),
    .rd    (mem_rd),
    .wr    (mem_wr)
);

// File: tb/acc_seq_top_tb_top.sv
module acc_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, halt, prog_we;
    logic [11:0] prog_addr, prog_data, peek_addr;
    logic [11:0] peek_data, pc_o, acc_o;
    logic [1:0]  major_o, minor_o;
    logic        instr_done, mem_rd, mem_wr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int rw_bad = 0;

    typedef struct packed {
        logic [11:0] pc;
        logic [11:0] acc;
        logic [7:0]  cycles;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    acc_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .pc_o(pc_o), .acc_o(acc_o), .major_o(major_o), .minor_o(minor_o),
        .instr_done(instr_done), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic poke(input logic [11:0] a, input logic [11:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic peek_chk(input string req, input logic [11:0] a, input logic [11:0] e);
        peek_addr = a;
        #1;
        chk(req, int'(peek_data), int'(e));
    endtask

    task automatic push(input string req, input logic [11:0] p, input logic [11:0] a,
                        input int c);
        exp_t e;
        e.pc = p; e.acc = a; e.cycles = 8'(c);
        sb_q.push_back(e);
        tag_q.push_back(req);
    endtask

    // monitor: cycle count per instruction and post-instruction state (R11 timing)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cyc = 0;
            end else begin
                if (mem_rd && mem_wr) rw_bad++;
                if (mem_wr && major_o != 2'd2) rw_bad++;
                if (!(major_o == 2'd0 && minor_o == 2'd0)) cyc++;
                if (instr_done) begin
                    automatic int took = cyc + 1;
                    cyc = 0;
                    @(negedge clk);
                    if (sb_q.size() == 0) begin
                        chk("R11 unexpected done", 1, 0);
                    end else begin
                        automatic exp_t  e = sb_q.pop_front();
                        automatic string t = tag_q.pop_front();
                        chk({t, " pc"}, int'(pc_o), int'(e.pc));
                        chk({t, " acc"}, int'(acc_o), int'(e.acc));
                        chk({t, " R11 cycles"}, took, int'(e.cycles));
                        chk("R11 back to fetch step 0", int'({major_o, minor_o}), 0);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; halt = 1'b1; prog_we = 1'b0;
        prog_addr = '0; prog_data = '0; peek_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", int'(pc_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc", int'(pc_o), 0);
        chk("R1 acc", int'(acc_o), 0);
        chk("R1 state", int'({major_o, minor_o}), 0);

        // data, page zero
        poke(12'o0050, 12'o0011);
        poke(12'o0100, 12'o0007);
        poke(12'o0101, 12'o0070);
        poke(12'o0102, 12'o7776);
        poke(12'o0103, 12'o7777);
        poke(12'o0104, 12'o0101);
        poke(12'o0105, 12'o0000);
        poke(12'o0106, 12'o0200);
        poke(12'o0107, 12'o7775);
        poke(12'o0110, 12'o0000);
        // data, page one
        poke(12'o0250, 12'o1234);
        poke(12'o0251, 12'o0000);
        poke(12'o0252, 12'o0100);
        // program
        poke(12'o0000, 12'o1100);
        poke(12'o0001, 12'o0101);
        poke(12'o0002, 12'o1504);
        poke(12'o0003, 12'o2102);
        poke(12'o0004, 12'o2103);
        poke(12'o0005, 12'o1100);
        poke(12'o0006, 12'o3105);
        poke(12'o0007, 12'o4110);
        poke(12'o0111, 12'o5510);
        poke(12'o0010, 12'o6000);
        poke(12'o0011, 12'o7000);
        poke(12'o0012, 12'o5506);
        poke(12'o0200, 12'o1250);
        poke(12'o0201, 12'o1050);
        poke(12'o0202, 12'o3251);
        poke(12'o0203, 12'o1652);
        poke(12'o0204, 12'o1107);
        poke(12'o0205, 12'o5206);
        poke(12'o0206, 12'o7000);

        // halted throughout loading
        chk("R2 pc held while halted", int'(pc_o), 0);
        chk("R2 state held while halted", int'({major_o, minor_o}), 0);
        peek_chk("R2 memory untouched", 12'o0110, 12'o0000);

        push("R4 add direct",             12'o0001, 12'o0007, 7);
        push("R4 and direct",             12'o0002, 12'o0000, 7);
        push("R5 add indirect",           12'o0003, 12'o0070, 10);
        push("R7 isz no skip",            12'o0004, 12'o0070, 8);
        push("R7 isz skip",               12'o0006, 12'o0070, 8);
        push("R8 store and clear",        12'o0007, 12'o0000, 6);
        push("R9 subroutine call",        12'o0111, 12'o0000, 6);
        push("R10 jump indirect return",  12'o0010, 12'o0000, 8);
        push("R3 io no-op",               12'o0011, 12'o0000, 4);
        push("R3 operate no-op",          12'o0012, 12'o0000, 4);
        push("R10 jump indirect page one",12'o0200, 12'o0000, 8);
        push("R6 add current page",       12'o0201, 12'o1234, 7);
        push("R6 add page zero",          12'o0202, 12'o1245, 7);
        push("R6 store current page",     12'o0203, 12'o0000, 6);
        push("R6 indirect via current page", 12'o0204, 12'o0007, 10);
        push("R4 add wraps",              12'o0205, 12'o0004, 7);
        push("R10 jump direct",           12'o0206, 12'o0004, 5);

        @(negedge clk);
        halt = 1'b0;
        wait (sb_q.size() == 0);
        halt = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 pc parked", int'(pc_o), int'(12'o0206));
        chk("R2 acc parked", int'(acc_o), int'(12'o0004));
        chk("R2 state parked", int'({major_o, minor_o}), 0);

        peek_chk("R7 isz written no skip", 12'o0102, 12'o7777);
        peek_chk("R7 isz written zero",    12'o0103, 12'o0000);
        peek_chk("R8 stored word",         12'o0105, 12'o0070);
        peek_chk("R9 return address",      12'o0110, 12'o0010);
        peek_chk("R6 current page store",  12'o0251, 12'o1245);
        peek_chk("R4 operand untouched",   12'o0100, 12'o0007);
        chk("R12 read/write overlap or write outside execute", rw_bad, 0);

        // reset in the middle of a fetch
        @(negedge clk);
        halt = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run not yet reset", int'(acc_o), int'(12'o0004));
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pc after mid-run reset", int'(pc_o), 0);
        chk("R1 acc after mid-run reset", int'(acc_o), 0);
        chk("R1 state after mid-run reset", int'({major_o, minor_o}), 0);
        halt = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule